// File: doc/BRIEF.md
# Serial Key Unlock for a Hidden Register Port

This block sits beside a byte-wide memory and watches every bus cycle that reaches it. Each cycle is a one-clock strobe, marked read or write, and carries one data bit taken from the least significant data line. Write cycles are compared, one bit at a time, against a fixed 64-bit key. A read cycle re-arms the comparison. When all 64 key bits have arrived in order, the block raises `unlocked`. The next fixed number of bus cycles are then routed away from the memory and towards a hidden register port. After that window, the block locks again.

While the block is locked, every cycle is passed through to the memory. A single wrong bit freezes the comparison, so the writes that follow cannot complete the key until a read starts a new attempt. An external active-low abort input can end an attempt or an open window, and a control bit decides whether that input is honoured or ignored. The serial transfer through the hidden port is handled elsewhere. This block only decides which cycles belong to it.

Top module: `serial_unlock`

## Requirements
- R1: After reset, `unlocked` is 0, the key pointer is at bit 0, and `memory_inhibit` is 0.
- R2: The key is the eight bytes C5h, 3Ah, A3h, 5Ch, C5h, 3Ah, A3h, 5Ch, taken in that byte order with each byte least significant bit first. Sixty-four write strobes whose `cyc_dq0` bits equal the key in that order raise `unlocked` on the clock edge that samples the 64th write. That 64th cycle itself still goes to memory.
- R3: While `unlocked` is 0, `memory_inhibit` is 0 on every strobe, read or write.
- R4: A write whose bit differs from the key bit at the pointer does not advance the pointer. Every later write is then ignored, including writes that carry the correct remaining key bits, until a read strobe or an abort.
- R5: A read strobe (`cyc_wr` = 0) while locked puts the pointer back to bit 0 and clears a previous mismatch. Key bits sent before the read do not count towards the key.
- R6: While `unlocked` is 1, `memory_inhibit` follows `cyc_stb`. Data bits are not compared. `unlocked` falls on the edge that samples the 64th strobe of the window, so the 65th strobe goes to memory again.
- R7: When the window ends, the pointer is back at bit 0, so a new full key sent with no read in front of it unlocks again.
- R8: With `rst_ign` = 0, a clock edge that sees `ext_rst_n` = 0 clears the pointer, clears a mismatch and closes an open window. With `rst_ign` = 1, `ext_rst_n` has no effect.
- R9: Clock cycles with `cyc_stb` = 0 neither advance the pointer nor count towards the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cyc_stb | input | 1 | One-clock strobe marking a bus cycle |
| cyc_wr | input | 1 | Cycle direction: 1 = write, 0 = read |
| cyc_dq0 | input | 1 | Data bit carried by the cycle |
| ext_rst_n | input | 1 | Active-low abort request, synchronous to clk |
| rst_ign | input | 1 | 1 = ignore `ext_rst_n`, 0 = honour it |
| unlocked | output | 1 | Hidden port owns the bus cycles |
| memory_inhibit | output | 1 | The current strobe must not reach memory |

## Verification
The hardest state to reach from the ports is a mismatch deep in the key, followed by the correct remainder of the key. Only there can a frozen pointer be told apart from a pointer that skips over the bad bit or resets itself. The bench sweeps the mismatch position over all 64 bits, and after each wrong bit it replays the key from that position onwards. It sweeps the position of a re-arming read the same way, and after each read it sends only the unsent tail of the key. Abort pulses are placed inside an open window and inside a partial key, once with the abort honoured and once with it ignored.

// File: rtl/serial_unlock_pkg.sv
package serial_unlock_pkg;

  // Key bytes C5,3A,A3,5C twice, byte 0 in the low bits; bit 0 goes first.
  localparam int                 KEY_BITS    = 64;
  localparam logic [KEY_BITS-1:0] DEFAULT_KEY = 64'h5CA3_3AC5_5CA3_3AC5;
  localparam int                 WINDOW_LEN  = 64;

  typedef enum logic [1:0] {
    CYC_NONE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_e;

endpackage

// File: rtl/unlock_rst_sync.sv
module unlock_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/unlock_key_matcher.sv
module unlock_key_matcher #(
  parameter int                  KEY_LEN = 64,
  parameter logic [KEY_LEN-1:0]  KEY     = '0,
  localparam int                 PTR_W   = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,      // abort or end of window
  input  logic arm,      // read strobe while locked
  input  logic wr_en,    // write strobe while locked
  input  logic bit_in,
  output logic hit
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(KEY_LEN - 1);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             fail_q, fail_d;
  logic             upd;

  always_comb begin
    ptr_d  = ptr_q;
    fail_d = fail_q;
    hit    = 1'b0;
    if (clr || arm) begin
      ptr_d  = '0;
      fail_d = 1'b0;
    end else if (wr_en && !fail_q) begin
      if (bit_in == KEY[ptr_q]) begin
        if (ptr_q == LAST) begin
          ptr_d = '0;
          hit   = 1'b1;
        end else begin
          ptr_d = ptr_q + 1'b1;
        end
      end else begin
        fail_d = 1'b1;
      end
    end
  end

  assign upd = clr | arm | (wr_en & ~fail_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      fail_q <= 1'b0;
    end else if (upd) begin
      ptr_q  <= ptr_d;
      fail_q <= fail_d;
    end
  end

  // R4: a mismatch stays latched until a read or a clear
  a_r4_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !clr && !arm) |=> fail_q);

  // R4: the pointer stays frozen while the mismatch is latched
  a_r4_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !clr && !arm) |=> $stable(ptr_q));

  // R5: a read re-arms the comparison from bit 0
  a_r5_read_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (ptr_q == '0 && !fail_q));

  // R7: after a full match the pointer is back at bit 0
  a_r7_hit_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (ptr_q == '0));

  // R9: without any strobe or clear the pointer holds
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !arm && !wr_en) |=> $stable(ptr_q));

endmodule

// File: rtl/unlock_xfer_window.sv
module unlock_xfer_window #(
  parameter int  XFER_LEN = 64,
  localparam int CNT_W    = (XFER_LEN > 1) ? $clog2(XFER_LEN) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_req,
  input  logic step,
  input  logic abort,
  output logic unlocked,
  output logic done
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(XFER_LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             unl_q, unl_d;
  logic             upd;

  always_comb begin
    unl_d = unl_q;
    cnt_d = cnt_q;
    done  = 1'b0;
    if (abort) begin
      unl_d = 1'b0;
      cnt_d = '0;
    end else if (unl_q && step) begin
      if (cnt_q == LAST) begin
        unl_d = 1'b0;
        cnt_d = '0;
        done  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (!unl_q && open_req) begin
      unl_d = 1'b1;
      cnt_d = '0;
    end
  end

  assign upd = abort | (unl_q & step) | (~unl_q & open_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unl_q <= 1'b0;
      cnt_q <= '0;
    end else if (upd) begin
      unl_q <= unl_d;
      cnt_q <= cnt_d;
    end
  end

  assign unlocked = unl_q;

  // R2: the window opens only after a full key match
  a_r2_rise_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unl_q) |-> $past(open_req));

  // R6: the window closes only at its end or on an abort
  a_r6_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unl_q) |-> $past(done || abort));

  // R6: the strobe count is idle while locked
  a_r6_cnt_idle_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !unl_q |-> (cnt_q == '0));

endmodule

// File: rtl/serial_unlock.sv
module serial_unlock
  import serial_unlock_pkg::*;
#(
  parameter int                 KEY_LEN  = KEY_BITS,
  parameter logic [KEY_LEN-1:0] KEY      = DEFAULT_KEY,
  parameter int                 XFER_LEN = WINDOW_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_stb,
  input  logic cyc_wr,
  input  logic cyc_dq0,
  input  logic ext_rst_n,
  input  logic rst_ign,
  output logic unlocked,
  output logic memory_inhibit
);

  logic      rst_s_n;
  cyc_kind_e kind;
  logic      abort;
  logic      lock_rd, lock_wr, win_step;
  logic      key_hit, win_done;

  unlock_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  always_comb begin
    if (!cyc_stb)    kind = CYC_NONE;
    else if (cyc_wr) kind = CYC_WRITE;
    else             kind = CYC_READ;
  end

  assign abort    = ~ext_rst_n & ~rst_ign;
  assign lock_rd  = (kind == CYC_READ)  & ~unlocked;
  assign lock_wr  = (kind == CYC_WRITE) & ~unlocked;
  assign win_step = (kind != CYC_NONE)  &  unlocked;

  unlock_key_matcher #(.KEY_LEN(KEY_LEN), .KEY(KEY)) u_match (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .clr    (abort | win_done),
    .arm    (lock_rd),
    .wr_en  (lock_wr),
    .bit_in (cyc_dq0),
    .hit    (key_hit)
  );

  unlock_xfer_window #(.XFER_LEN(XFER_LEN)) u_win (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .open_req (key_hit),
    .step     (win_step),
    .abort    (abort),
    .unlocked (unlocked),
    .done     (win_done)
  );

  assign memory_inhibit = cyc_stb & unlocked;

  // R8: an honoured abort leaves the block locked
  a_r8_abort_locks: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!ext_rst_n && !rst_ign) |=> !unlocked);

  // R3: strobes while locked are never inhibited
  a_r3_locked_passes: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cyc_stb && !unlocked) |-> !memory_inhibit);

endmodule

// File: tb/tb_serial_unlock.sv
module tb_serial_unlock;

  logic clk = 1'b0;
  logic rst_n, cyc_stb, cyc_wr, cyc_dq0, ext_rst_n, rst_ign;
  logic unlocked, memory_inhibit;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  // bench-side expected state
  int m_ptr;
  bit m_fail;
  bit m_unl;
  int m_cnt;

  serial_unlock dut (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .cyc_wr(cyc_wr),
    .cyc_dq0(cyc_dq0), .ext_rst_n(ext_rst_n), .rst_ign(rst_ign),
    .unlocked(unlocked), .memory_inhibit(memory_inhibit)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic kbit(int i);
    logic [7:0] b;
    case ((i / 8) % 4)
      0: b = 8'hC5;
      1: b = 8'h3A;
      2: b = 8'hA3;
      default: b = 8'h5C;
    endcase
    return b[i % 8];
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_ptr = 0; m_fail = 0; m_unl = 0; m_cnt = 0;
  endtask

  task automatic model_step(bit wr, bit b);
    if (m_unl) begin
      m_cnt++;
      if (m_cnt == 64) begin
        m_unl = 0; m_cnt = 0; m_ptr = 0; m_fail = 0;
      end
    end else if (!wr) begin
      m_ptr = 0; m_fail = 0;
    end else if (!m_fail) begin
      if (b == kbit(m_ptr)) begin
        if (m_ptr == 63) begin m_unl = 1; m_ptr = 0; end
        else m_ptr++;
      end else begin
        m_fail = 1;
      end
    end
  endtask

  // one bus cycle, then idle clocks; checks inhibit and unlocked
  task automatic bus(bit wr, bit b, string tag, int idle = 0);
    @(negedge clk);
    cyc_stb = 1; cyc_wr = wr; cyc_dq0 = b;
    #1;
    chk(m_unl ? "R6 inhibit" : "R3 inhibit", memory_inhibit, m_unl);
    @(posedge clk);
    model_step(wr, b);
    @(negedge clk);
    cyc_stb = 0;
    #1;
    chk(tag, unlocked, m_unl);
    repeat (idle) @(negedge clk);
  endtask

  task automatic send_key(int from, int to, string tag, int idle = 0);
    for (int i = from; i <= to; i++) bus(1, kbit(i), tag, idle);
  endtask

  task automatic drain(string tag);
    for (int i = 0; i < 64; i++) bus(i % 2, i % 3 == 0, tag);
  endtask

  task automatic pulse_abort(bit ign, string tag);
    @(negedge clk);
    ext_rst_n = 0; rst_ign = ign;
    @(posedge clk);
    if (!ign) model_clear();
    @(negedge clk);
    ext_rst_n = 1; rst_ign = 1;
    #1;
    chk(tag, unlocked, m_unl);
  endtask

  initial begin
    rst_n = 0; cyc_stb = 0; cyc_wr = 0; cyc_dq0 = 0;
    ext_rst_n = 1; rst_ign = 1;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 unlocked", unlocked, 1'b0);
    chk("R1 inhibit", memory_inhibit, 1'b0);

    // R1 pointer at bit 0, R2 full key opens
    send_key(0, 63, "R2 key");
    chk("R2 open", unlocked, 1'b1);
    drain("R6 window");
    chk("R6 closed", unlocked, 1'b0);
    bus(0, 0, "R6 after window");
    // R7 no read needed after the window
    send_key(0, 63, "R7 rekey");
    chk("R7 open", unlocked, 1'b1);
    drain("R6 window");

    // R4 mismatch at every position, then correct remainder
    for (int k = 0; k < 64; k++) begin
      bus(0, 0, "R5 arm");
      if (k > 0) send_key(0, k - 1, "R4 prefix");
      bus(1, !kbit(k), "R4 bad bit");
      send_key(k, 63, "R4 ignored");
      chk("R4 still locked", unlocked, 1'b0);
      bus(0, 0, "R5 arm");
      send_key(0, 63, "R5 recover");
      chk("R5 open after read", unlocked, 1'b1);
      drain("R6 window");
    end

    // R5 read at every position, then only the unsent tail
    for (int k = 1; k < 64; k++) begin
      send_key(0, k - 1, "R5 prefix");
      bus(0, 1, "R5 read");
      send_key(k, 63, "R5 tail");
      chk("R5 tail locked", unlocked, 1'b0);
      bus(0, 0, "R5 arm");
    end

    // R8 honoured abort inside a window
    send_key(0, 63, "R8 key");
    for (int i = 0; i < 10; i++) bus(1, 1, "R6 window");
    pulse_abort(0, "R8 abort closes");
    bus(1, 0, "R8 after abort");
    bus(0, 0, "R5 arm");
    send_key(0, 29, "R8 partial");
    pulse_abort(0, "R8 abort partial");
    send_key(30, 63, "R8 tail");
    chk("R8 tail locked", unlocked, 1'b0);
    // R8 ignored abort
    bus(0, 0, "R5 arm");
    send_key(0, 29, "R8 partial");
    pulse_abort(1, "R8 ignored");
    send_key(30, 63, "R8 ignored key");
    chk("R8 ignored open", unlocked, 1'b1);
    for (int i = 0; i < 20; i++) bus(1, 0, "R6 window");
    pulse_abort(1, "R8 ignored window");
    chk("R8 window kept", unlocked, 1'b1);
    for (int i = 0; i < 44; i++) bus(0, 1, "R6 window");
    chk("R8 window end", unlocked, 1'b0);

    // R9 idle clocks between strobes
    send_key(0, 63, "R9 gapped key", 3);
    chk("R9 open", unlocked, 1'b1);
    for (int i = 0; i < 64; i++) bus(1, 1, "R9 gapped window", i % 4);
    chk("R9 closed", unlocked, 1'b0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule